// File: doc/BRIEF.md
# Strided 2D DMA address generator

This block produces the sequence of beat addresses for the memory side of a DMA channel that moves a rectangular region. A descriptor gives a start address, a row length and a row count (both as value minus one), a row stride and a cyclic flag. The block then walks the region row by row. Inside a row the address grows by one bus width per accepted beat. Each new row begins one stride past the start of the previous row, so a stride wider than the row skips the gap between rows.

Addresses go out over a valid/ready handshake, with flags for the last beat of a row and the last beat of the region. A one-cycle done pulse follows the final beat. In cyclic mode the walk starts again from the original start address and done is never raised. An abort input drops the walk at once. A parameter removes the address arithmetic for a side attached to a streaming peripheral; the beat counting and the done pulse still work on that side.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the block is idle: desc_ready is 1, and beat_valid, busy, done and cur_addr are all 0.
- R2: The first beat address is the descriptor start address with its low log2(BEAT_BYTES) bits forced to zero. Within a row, each accepted beat raises the address by BEAT_BYTES.
- R3: A row holds (desc_xlen_m1 >> log2(BEAT_BYTES)) + 1 beats; the low bits of desc_xlen_m1 are ignored. beat_row_last is 1 on the final beat of every row.
- R4: A region holds desc_ylen_m1 + 1 rows, so 0 means a single row. Each row starts at the previous row start plus desc_stride, with the stride's low log2(BEAT_BYTES) bits cleared. This holds whatever the row length is.
- R5: beat_last is 1 on the final beat of the final row. In non-cyclic mode, done is 1 for exactly the one cycle after that beat is accepted. In that same cycle busy is 0 and desc_ready is 1.
- R6: While beat_valid is 1 and beat_ready is 0, beat_addr holds its value.
- R7: With desc_cyclic set, the beat after the final beat uses the original start address again, busy stays 1, and done is never raised.
- R8: While abort is 1, beat_valid is 0. If the block is busy when abort is 1, it is idle in the next cycle and done stays 0.
- R9: cur_addr equals the address of the most recently accepted beat and holds between accepted beats.
- R10: With ADDR_EN = 0, beat_addr and cur_addr are always 0. Beat count, flags and done behave as with ADDR_EN = 1.
- R11: A descriptor presented while busy is ignored: desc_ready is 0, and the walk in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Block idle, descriptor will be taken |
| desc_addr | input | ADDR_W | Region start address |
| desc_xlen_m1 | input | LEN_W | Row length in bytes minus one |
| desc_ylen_m1 | input | LEN_W | Row count minus one |
| desc_stride | input | LEN_W | Byte distance between row starts |
| desc_cyclic | input | 1 | Restart at the end instead of finishing |
| abort | input | 1 | Drop the walk and return to idle |
| beat_valid | output | 1 | beat_addr holds a beat to issue |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | ADDR_W | Address of the offered beat |
| beat_row_last | output | 1 | Offered beat ends a row |
| beat_last | output | 1 | Offered beat ends the region |
| cur_addr | output | ADDR_W | Address of the last accepted beat |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
A wrong column counter shows up at the end of the first row: the row-last flag lands on the wrong beat, and the next address misses the stride jump. A wrong row counter stays hidden until the final row, where beat_last and done come too early or too late. An error in the row-base register shows up as a wrong address on the first beat of the second row. Cyclic restart and abort each show their effect in the very next cycle, through the repeated start address or a dropped beat_valid.

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 8,
  parameter bit ADDR_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_xlen_m1,
  input  logic [LEN_W-1:0]  desc_ylen_m1,
  input  logic [LEN_W-1:0]  desc_stride,
  input  logic              desc_cyclic,
  input  logic              abort,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_row_last,
  output logic              beat_last,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              busy,
  output logic              done
);
  localparam int SH    = $clog2(BEAT_BYTES);
  localparam int COL_W = LEN_W - SH;
  localparam logic [ADDR_W-1:0] AMASK = ~(ADDR_W'(BEAT_BYTES - 1));
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(BEAT_BYTES);

  logic             busy_q, cyc_q, done_q;
  logic [COL_W-1:0] col_q, cols_m1_q;
  logic [LEN_W-1:0] row_q, rows_m1_q;

  logic load, fire, col_end, all_end;
  assign load    = desc_valid & ~busy_q;
  assign fire    = beat_valid & beat_ready;
  assign col_end = col_q == cols_m1_q;
  assign all_end = col_end & (row_q == rows_m1_q);

  assign desc_ready    = ~busy_q;
  assign busy          = busy_q;
  assign done          = done_q;
  assign beat_valid    = busy_q & ~abort;
  assign beat_row_last = beat_valid & col_end;
  assign beat_last     = beat_valid & all_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cyc_q     <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      cols_m1_q <= '0;
      rows_m1_q <= '0;
    end else if (load) begin
      busy_q    <= 1'b1;
      cyc_q     <= desc_cyclic;
      col_q     <= '0;
      row_q     <= '0;
      cols_m1_q <= desc_xlen_m1[LEN_W-1:SH];
      rows_m1_q <= desc_ylen_m1;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (fire) begin
      if (all_end) begin
        col_q <= '0;
        row_q <= '0;
        if (!cyc_q) busy_q <= 1'b0;
      end else if (col_end) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fire & all_end & ~cyc_q;
  end

  generate
    if (ADDR_EN) begin : g_addr
      logic [ADDR_W-1:0] addr_q, base_q, start_q, stride_q, cur_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          addr_q   <= '0;
          base_q   <= '0;
          start_q  <= '0;
          stride_q <= '0;
          cur_q    <= '0;
        end else if (load) begin
          addr_q   <= desc_addr & AMASK;
          base_q   <= desc_addr & AMASK;
          start_q  <= desc_addr & AMASK;
          stride_q <= ADDR_W'(desc_stride) & AMASK;
        end else if (fire) begin
          cur_q <= addr_q;
          if (all_end) begin
            addr_q <= start_q;
            base_q <= start_q;
          end else if (col_end) begin
            addr_q <= base_q + stride_q;
            base_q <= base_q + stride_q;
          end else begin
            addr_q <= addr_q + STEP;
          end
        end
      end
      assign beat_addr = addr_q;
      assign cur_addr  = cur_q;
    end else begin : g_noaddr
      assign beat_addr = '0;
      assign cur_addr  = '0;
    end
  endgenerate
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic              abort,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              beat_last,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              busy,
  input logic              done
);
  localparam logic [ADDR_W-1:0] LOW = ADDR_W'(BEAT_BYTES - 1);

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr & LOW) == '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> $stable(beat_addr));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(beat_valid && beat_ready && beat_last));
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> (!busy && !done));
  a_r8_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !beat_valid);
  a_r9_cur: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready) |=> cur_addr == $past(beat_addr));
  a_r11_take: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> busy);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .abort(abort), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_addr(beat_addr), .beat_last(beat_last), .cur_addr(cur_addr),
  .busy(busy), .done(done)
);

// File: tb/test_dma2d_addr_gen.sv
`timescale 1ns/1ps
module test_dma2d_addr_gen;
  localparam int AW = 32, LW = 16, BB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_valid = 1'b0, desc_cyclic = 1'b0, abort = 1'b0, beat_ready = 1'b0;
  logic [AW-1:0] desc_addr = '0;
  logic [LW-1:0] desc_xlen_m1 = '0, desc_ylen_m1 = '0, desc_stride = '0;
  logic desc_ready, beat_valid, beat_row_last, beat_last, busy, done;
  logic [AW-1:0] beat_addr, cur_addr;
  logic n_desc_ready, n_valid, n_row_last, n_last, n_busy, n_done;
  logic [AW-1:0] n_addr, n_cur;

  always #2.5 clk = ~clk;

  dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB)) i_dma2d_addr_gen (
    .clk, .rst_n, .desc_valid, .desc_ready, .desc_addr, .desc_xlen_m1,
    .desc_ylen_m1, .desc_stride, .desc_cyclic, .abort, .beat_valid, .beat_ready,
    .beat_addr, .beat_row_last, .beat_last, .cur_addr, .busy, .done);

  dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB), .ADDR_EN(1'b0)) i_dma2d_addr_gen_noaddr (
    .clk, .rst_n, .desc_valid, .desc_ready(n_desc_ready), .desc_addr, .desc_xlen_m1,
    .desc_ylen_m1, .desc_stride, .desc_cyclic, .abort, .beat_valid(n_valid), .beat_ready,
    .beat_addr(n_addr), .beat_row_last(n_row_last), .beat_last(n_last),
    .cur_addr(n_cur), .busy(n_busy), .done(n_done));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // addr, xlen_m1, ylen_m1, stride, beats, final address
  localparam int unsigned VEC [5][6] = '{
    '{32'h1000, 15, 2, 32'h100, 6, 32'h1208},
    '{32'h2000,  7, 0, 32'h0,   1, 32'h2000},
    '{32'h3008, 31, 1, 32'h20,  8, 32'h3040},
    '{32'h4007, 23, 1, 32'h45,  6, 32'h4050},
    '{32'h5000, 15, 3, 32'h8,   8, 32'h5020}
  };

  task automatic give_desc(input int unsigned a, x, y, s, input bit cyc);
    @(negedge clk);
    desc_valid = 1'b1; desc_addr = a; desc_xlen_m1 = LW'(x);
    desc_ylen_m1 = LW'(y); desc_stride = LW'(s); desc_cyclic = cyc;
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic walk(input int unsigned a, x, y, s, nb_exp, last_exp, input bit bp);
    int nb = (x >> 3) + 1;
    int nr = y + 1;
    int idx = 0;
    int cyc = 0;
    longint unsigned ea = 0;
    chk(nb * nr == nb_exp, "R3", nb * nr, nb_exp);
    give_desc(a, x, y, s, 1'b0);
    while (idx < nb * nr && cyc < 2000) begin
      @(negedge clk);
      beat_ready = bp ? (cyc % 3 != 0) : 1'b1;
      cyc++;
      #1;
      if (beat_valid && !beat_ready) begin
        longint unsigned held = beat_addr;
        @(negedge clk); #1;
        chk(beat_addr == held, "R6", beat_addr, held);
      end else if (beat_valid) begin
        ea = (a & ~32'h7) + (idx / nb) * (s & ~32'h7) + (idx % nb) * BB;
        chk(beat_addr == ea, "R2 R4 addr", beat_addr, ea);
        chk(beat_row_last == (idx % nb == nb - 1), "R3 row_last", beat_row_last, idx % nb == nb - 1);
        chk(beat_last == (idx == nb * nr - 1), "R5 last", beat_last, idx == nb * nr - 1);
        chk(n_valid && n_addr == 0 && n_last == beat_last && n_row_last == beat_row_last,
            "R10 noaddr beat", n_addr, 0);
        idx++;
      end
    end
    @(negedge clk); beat_ready = 1'b0; #1;
    chk(done && !busy && desc_ready, "R5 done", {done, busy, desc_ready}, 3'b101);
    chk(n_done && n_cur == 0, "R10 noaddr done", {n_done, n_cur != 0}, 2'b10);
    chk(cur_addr == last_exp, "R9 cur_addr", cur_addr, last_exp);
    chk(ea == last_exp, "R4 final", ea, last_exp);
    @(negedge clk); #1;
    chk(!done && cur_addr == last_exp, "R5 R9 pulse", {done, cur_addr}, last_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(desc_ready && !beat_valid && !busy && !done && cur_addr == 0, "R1 held reset",
        {desc_ready, beat_valid, busy, done}, 4'b1000);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(desc_ready && !beat_valid && !busy && !done && cur_addr == 0, "R1 idle",
        {desc_ready, beat_valid, busy, done}, 4'b1000);

    for (int v = 0; v < 5; v++)
      walk(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], v[0]);

    // R11: second descriptor while busy is ignored
    give_desc(32'h7000, 15, 0, 0, 1'b0);
    @(negedge clk);
    desc_valid = 1'b1; desc_addr = 32'h9000; desc_xlen_m1 = 0; #1;
    chk(!desc_ready && beat_addr == 32'h7000, "R11 busy", beat_addr, 32'h7000);
    @(negedge clk); desc_valid = 1'b0; beat_ready = 1'b1; #1;
    chk(beat_addr == 32'h7000 && !beat_last, "R11 first", beat_addr, 32'h7000);
    @(negedge clk); #1;
    chk(beat_addr == 32'h7008 && beat_last, "R11 second", beat_addr, 32'h7008);
    @(negedge clk); beat_ready = 1'b0; #1;
    chk(done && !beat_valid, "R11 end", done, 1);
    @(negedge clk); #1;
    chk(!beat_valid && !busy, "R11 idle", busy, 0);

    // R7: cyclic restart, two one-beat rows
    give_desc(32'h6000, 7, 1, 32'h10, 1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); beat_ready = 1'b1; #1;
      chk(beat_valid && beat_addr == ((k % 2) ? 32'h6010 : 32'h6000), "R7 cyclic addr",
          beat_addr, (k % 2) ? 32'h6010 : 32'h6000);
      chk(!done && busy, "R7 no done", done, 0);
    end

    // R8: abort
    @(negedge clk); abort = 1'b1; #1;
    chk(!beat_valid, "R8 valid drop", beat_valid, 0);
    @(negedge clk); abort = 1'b0; #1;
    chk(!busy && !beat_valid && !done && desc_ready, "R8 idle", {busy, done}, 0);
    @(negedge clk); #1;
    chk(!done && !beat_valid, "R8 stays idle", done, 0);

    // R8: abort during a non-cyclic walk, no done
    give_desc(32'h8000, 31, 2, 32'h40, 1'b0);
    @(negedge clk); #1;
    chk(beat_addr == 32'h8008, "R2 step", beat_addr, 32'h8008);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0; beat_ready = 1'b0; #1;
    chk(!busy && !done && desc_ready, "R8 mid walk", {busy, done}, 0);
    @(negedge clk); #1;
    chk(!done && cur_addr == 32'h8000, "R8 R9 after abort", cur_addr, 32'h8000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule